// File: doc/BRIEF.md
# Configuration Access Request Validator

This block sits between a requester that issues configuration reads and writes and the configuration register space of a device. Each request names a bus, a packed device/function byte, a register offset, an access size of one, two or four bytes, a direction and 32-bit write data. The block splits the device/function byte into its two fields and decides whether the offset is legal for the requested size. Only after that does it let the request reach the register space.

A legal request becomes a single-cycle access to the 32-bit word that holds the offset. The access carries byte enables for the addressed bytes, and its write data is shifted into the matching byte lanes. Read data that comes back is shifted down and trimmed to the access size. An illegal request never reaches the register space and is answered with an error code and a failure flag. Every request gets exactly one response, one clock after its strobe.

Top module: `cfgAccessGate`

## Requirements
- R1: While a request is presented, the forwarded bus number equals the request bus number, the forwarded device number equals bits 7..3 of the device/function byte and the forwarded function number equals bits 2..0.
- R2: With size code 0 (one byte) every offset from 00h to FFh is accepted, and any offset of 100h or above is rejected.
- R3: With size code 1 (two bytes) an offset is accepted only if it is even and below 100h.
- R4: With size code 2 (four bytes) an offset is accepted only if it is a multiple of 4 and below 100h.
- R5: An accepted request answers with status 00h and the failure flag low.
- R6: A rejected request, including any request with the unused size code 3, answers with status 87h and the failure flag high.
- R7: A rejected request drives neither the access enable nor the write enable to the register space, so nothing in it changes.
- R8: For an accepted request the byte enables mark the bytes from lane offset[1:0] up to that lane plus the size minus one. Write data byte k goes to lane offset[1:0]+k, and the word address is offset[7:2].
- R9: An accepted read returns the addressed bytes right-aligned, with all bits above the access size zero. Any write or rejected request returns zero read data.
- R10: The response (done, status, flag, data) appears on the clock edge after the request strobe. Done is high for exactly that one cycle per strobe. After reset, done, status, flag and data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqBus | input | 8 | Bus number |
| reqDevFn | input | 8 | Device (bits 7..3) and function (bits 2..0) |
| reqOffset | input | 16 | Register offset in bytes |
| reqSize | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 unused |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 32 | Write data, right-aligned |
| cfgEn | output | 1 | Access strobe to the register space |
| cfgWe | output | 1 | Write qualifier for the access |
| cfgBus | output | 8 | Forwarded bus number |
| cfgDev | output | 5 | Forwarded device number |
| cfgFn | output | 3 | Forwarded function number |
| cfgDwordAddr | output | 6 | Word address inside the register space |
| cfgByteEn | output | 4 | Byte lane enables |
| cfgWdata | output | 32 | Lane-steered write data |
| cfgRdata | input | 32 | Read word from the register space, same cycle |
| rspDone | output | 1 | Response pulse |
| rspStatus | output | 8 | Status code, 00h or 87h |
| rspFail | output | 1 | Failure flag |
| rspRdata | output | 32 | Right-aligned read data |

## Verification
Most faults in this block are decision faults or steering faults. A wrong decision is visible in the same cycle as the request, because cfgEn or cfgWe toggles when it should stay low. One edge later the status and flag show the wrong code, and a write that should have been refused shows up as changed contents on the next read of that word. A steering fault in the byte enables, write lanes or read alignment shows up as misplaced bytes on that later read, or on rspRdata one edge after the read strobe. A fault in the response register makes done miss or stretch the single-cycle pulse.

// File: rtl/cfgGatePkg.sv
package cfgGatePkg;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  localparam logic [7:0] ST_OK      = 8'h00;
  localparam logic [7:0] ST_BAD_REG = 8'h87;

  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic issue;    // legal request, access the register space
    logic write;    // legal write
    logic respond;  // any request, produce a response next edge
    logic fail;     // rejected request
  } gateStrobeT;

endpackage

// File: rtl/cfgGateCtrl.sv
module cfgGateCtrl
  import cfgGatePkg::*;
#(
  parameter int OFFSET_W    = 16,
  parameter int SPACE_BYTES = 256
) (
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [1:0]          reqSize,
  input  logic [OFFSET_W-1:0] reqOffset,
  output gateStrobeT          strobe
);

  localparam logic [OFFSET_W-1:0] SPACE_LIM = OFFSET_W'(SPACE_BYTES);

  logic                sizeOk;
  logic [OFFSET_W-1:0] alignMask;
  logic                aligned;
  logic                inRange;
  logic                legal;

  always_comb begin
    sizeOk    = 1'b1;
    alignMask = '0;
    unique case (reqSize)
      SZ_BYTE:  alignMask = OFFSET_W'(0);
      SZ_WORD:  alignMask = OFFSET_W'(1);
      SZ_DWORD: alignMask = OFFSET_W'(3);
      default:  sizeOk    = 1'b0;
    endcase
  end

  assign aligned = (reqOffset & alignMask) == '0;
  assign inRange = reqOffset < SPACE_LIM;
  assign legal   = sizeOk && aligned && inRange;

  always_comb begin
    strobe.issue   = reqValid && legal;
    strobe.write   = reqValid && legal && reqWrite;
    strobe.respond = reqValid;
    strobe.fail    = reqValid && !legal;
  end

  // R4: a four-byte access that gets through sits on a word boundary
  always_comb begin
    if (strobe.issue && reqSize == SZ_DWORD)
      a_r4_dword_aligned: assert (reqOffset[1:0] == 2'b00);
  end

  // R3: a two-byte access that gets through is even
  always_comb begin
    if (strobe.issue && reqSize == SZ_WORD)
      a_r3_word_even: assert (reqOffset[0] == 1'b0);
  end

endmodule

// File: rtl/cfgGateDatapath.sv
module cfgGateDatapath
  import cfgGatePkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gateStrobeT               strobe,
  input  logic [1:0]               reqSize,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        cfgRdata,
  output logic                     cfgEn,
  output logic                     cfgWe,
  output logic [DATA_W/8-1:0]      cfgByteEn,
  output logic [DATA_W-1:0]        cfgWdata,
  output logic                     rspDone,
  output logic [7:0]               rspStatus,
  output logic                     rspFail,
  output logic [DATA_W-1:0]        rspRdata
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W:0]     accBytes;
  logic [LANE_W:0]     laneLo;
  logic [LANE_W:0]     laneHi;
  logic [DATA_W-1:0]   rdShifted;
  logic [DATA_W-1:0]   rdAligned;
  logic [LANES-1:0]    keepLane;

  always_comb begin
    unique case (reqSize)
      SZ_BYTE:  accBytes = (LANE_W+1)'(1);
      SZ_WORD:  accBytes = (LANE_W+1)'(2);
      SZ_DWORD: accBytes = (LANE_W+1)'(4);
      default:  accBytes = '0;
    endcase
  end

  assign laneLo = {1'b0, lane};
  assign laneHi = laneLo + accBytes;

  assign cfgEn     = strobe.issue;
  assign cfgWe     = strobe.write;
  assign cfgWdata  = reqWdata << {lane, 3'b000};
  assign rdShifted = cfgRdata >> {lane, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_W:0] IDX = (LANE_W+1)'(i);
    assign cfgByteEn[i]          = strobe.issue && (IDX >= laneLo) && (IDX < laneHi);
    assign keepLane[i]           = IDX < accBytes;
    assign rdAligned[8*i +: 8]   = rdShifted[8*i +: 8] & {8{keepLane[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDone   <= 1'b0;
      rspStatus <= ST_OK;
      rspFail   <= 1'b0;
      rspRdata  <= '0;
    end else begin
      rspDone <= strobe.respond;
      if (strobe.respond) begin
        rspStatus <= strobe.fail ? ST_BAD_REG : ST_OK;
        rspFail   <= strobe.fail;
        rspRdata  <= (strobe.issue && !strobe.write) ? rdAligned : '0;
      end
    end
  end

  // R6: the flag and the error code travel together
  a_r6_fail_code: assert property (@(posedge clk) disable iff (!rstN)
    rspFail |-> rspStatus == ST_BAD_REG);

  // R5: a clean response carries the success code
  a_r5_ok_code: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && !rspFail) |-> rspStatus == ST_OK);

  // R9: a refused request returns no data
  a_r9_fail_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    rspFail |-> rspRdata == '0);

  // R8: a one-byte access enables exactly one lane
  a_r8_byte_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && reqSize == SZ_BYTE) |-> $countones(cfgByteEn) == 1);

  // R7: without an access strobe no byte lane is enabled
  a_r7_no_lane_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |-> cfgByteEn == '0);

endmodule

// File: rtl/cfgAccessGate.sv
module cfgAccessGate
  import cfgGatePkg::*;
#(
  parameter int OFFSET_W    = 16,
  parameter int SPACE_BYTES = 256,
  parameter int DATA_W      = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [7:0]          reqBus,
  input  logic [7:0]          reqDevFn,
  input  logic [OFFSET_W-1:0] reqOffset,
  input  logic [1:0]          reqSize,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                cfgEn,
  output logic                cfgWe,
  output logic [7:0]          cfgBus,
  output logic [4:0]          cfgDev,
  output logic [2:0]          cfgFn,
  output logic [$clog2(SPACE_BYTES)-$clog2(DATA_W/8)-1:0] cfgDwordAddr,
  output logic [DATA_W/8-1:0] cfgByteEn,
  output logic [DATA_W-1:0]   cfgWdata,
  input  logic [DATA_W-1:0]   cfgRdata,
  output logic                rspDone,
  output logic [7:0]          rspStatus,
  output logic                rspFail,
  output logic [DATA_W-1:0]   rspRdata
);

  localparam int LANE_W = $clog2(DATA_W/8);
  localparam int BYTE_W = $clog2(SPACE_BYTES);

  gateStrobeT strobe;

  assign cfgBus       = reqBus;
  assign cfgDev       = reqDevFn[7:3];
  assign cfgFn        = reqDevFn[2:0];
  assign cfgDwordAddr = reqOffset[BYTE_W-1:LANE_W];

  cfgGateCtrl #(
    .OFFSET_W   (OFFSET_W),
    .SPACE_BYTES(SPACE_BYTES)
  ) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqOffset(reqOffset),
    .strobe   (strobe)
  );

  cfgGateDatapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqSize  (reqSize),
    .lane     (reqOffset[LANE_W-1:0]),
    .reqWdata (reqWdata),
    .cfgRdata (cfgRdata),
    .cfgEn    (cfgEn),
    .cfgWe    (cfgWe),
    .cfgByteEn(cfgByteEn),
    .cfgWdata (cfgWdata),
    .rspDone  (rspDone),
    .rspStatus(rspStatus),
    .rspFail  (rspFail),
    .rspRdata (rspRdata)
  );

  // R10: each strobe is answered on the next edge
  a_r10_done_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspDone);

  // R10: no response without a strobe one edge earlier
  a_r10_done_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspDone);

  // R7: an access that reaches the space is never reported as refused
  a_r7_access_not_failed: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> !rspFail);

  // R7: a write qualifier never appears without the access strobe
  a_r7_we_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> cfgEn);

endmodule

// File: tb/cfgAccessGate_tb.sv
module cfgAccessGate_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  sz;
    logic        wr;
    logic [15:0] off;
    logic [31:0] wd;
    logic        fail;
    logic [31:0] rd;
  } vecT;

  localparam int NV = 19;
  localparam vecT VECS [NV] = '{
    '{2'd0, 1'b0, 16'h0003, 32'h0, 1'b0, 32'h00000003},   // R2
    '{2'd0, 1'b0, 16'h00FF, 32'h0, 1'b0, 32'h000000FF},   // R2 top byte
    '{2'd0, 1'b0, 16'h0100, 32'h0, 1'b1, 32'h0},          // R2 out of range
    '{2'd1, 1'b0, 16'h0022, 32'h0, 1'b0, 32'h00002322},   // R3
    '{2'd1, 1'b0, 16'h0023, 32'h0, 1'b1, 32'h0},          // R3 odd
    '{2'd1, 1'b0, 16'h0100, 32'h0, 1'b1, 32'h0},          // R3 range
    '{2'd2, 1'b0, 16'h0040, 32'h0, 1'b0, 32'h43424140},   // R4
    '{2'd2, 1'b0, 16'h0042, 32'h0, 1'b1, 32'h0},          // R4 misaligned
    '{2'd2, 1'b0, 16'h00FC, 32'h0, 1'b0, 32'hFFFEFDFC},   // R4 last word
    '{2'd1, 1'b1, 16'h0036, 32'h0000BEEF, 1'b0, 32'h0},   // R8 write upper half
    '{2'd2, 1'b0, 16'h0034, 32'h0, 1'b0, 32'hBEEF3534},   // R8 readback
    '{2'd2, 1'b1, 16'h0051, 32'h12345678, 1'b1, 32'h0},   // R7 refused write
    '{2'd2, 1'b0, 16'h0050, 32'h0, 1'b0, 32'h53525150},   // R7 unchanged
    '{2'd0, 1'b1, 16'h0061, 32'h000000AA, 1'b0, 32'h0},   // R8 byte lane 1
    '{2'd2, 1'b0, 16'h0060, 32'h0, 1'b0, 32'h6362AA60},   // R8 readback
    '{2'd3, 1'b0, 16'h0000, 32'h0, 1'b1, 32'h0},          // R6 unused size
    '{2'd2, 1'b1, 16'h0070, 32'hCAFEF00D, 1'b0, 32'h0},   // R9 write gives zero data
    '{2'd1, 1'b0, 16'h0072, 32'h0, 1'b0, 32'h0000CAFE},   // R9 upper half
    '{2'd0, 1'b0, 16'h0071, 32'h0, 1'b0, 32'h000000F0}    // R9 single byte
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [7:0]  reqDevFn = '0;
  logic [15:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        cfgEn, cfgWe;
  logic [7:0]  cfgBus;
  logic [4:0]  cfgDev;
  logic [2:0]  cfgFn;
  logic [5:0]  cfgDwordAddr;
  logic [3:0]  cfgByteEn;
  logic [31:0] cfgWdata, cfgRdata;
  logic        rspDone, rspFail;
  logic [7:0]  rspStatus;
  logic [31:0] rspRdata;

  logic [7:0]  mem [256];
  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgAccessGate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBus(reqBus),
    .reqDevFn(reqDevFn), .reqOffset(reqOffset), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .cfgEn(cfgEn), .cfgWe(cfgWe),
    .cfgBus(cfgBus), .cfgDev(cfgDev), .cfgFn(cfgFn),
    .cfgDwordAddr(cfgDwordAddr), .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .rspDone(rspDone), .rspStatus(rspStatus),
    .rspFail(rspFail), .rspRdata(rspRdata)
  );

  // register space model: byte k of the space initially holds k
  assign cfgRdata = {mem[{cfgDwordAddr, 2'd3}], mem[{cfgDwordAddr, 2'd2}],
                     mem[{cfgDwordAddr, 2'd1}], mem[{cfgDwordAddr, 2'd0}]};

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
  end

  always @(posedge clk) begin
    if (cfgEn && cfgWe) begin
      for (int k = 0; k < 4; k++)
        if (cfgByteEn[k]) mem[{cfgDwordAddr, 2'(k)}] <= cfgWdata[8*k +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [1:0] sz, input logic wr,
                         input logic [15:0] off, input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqSize = sz; reqWrite = wr; reqOffset = off; reqWdata = wd;
    #1;
  endtask

  task automatic release_req();
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(rspDone == 1'b0, "R10 reset done", 32'(rspDone), 32'd0);
    chk(rspStatus == 8'h00, "R10 reset status", 32'(rspStatus), 32'd0);
    chk(rspFail == 1'b0, "R10 reset flag", 32'(rspFail), 32'd0);
    chk(rspRdata == 32'h0, "R10 reset data", rspRdata, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R1 field split
    reqBus = 8'h5C; reqDevFn = 8'hAB;
    present(2'd0, 1'b0, 16'h0010, 32'h0);
    chk(cfgBus == 8'h5C, "R1 bus", 32'(cfgBus), 32'h5C);
    chk(cfgDev == 5'h15, "R1 device", 32'(cfgDev), 32'h15);
    chk(cfgFn == 3'h3, "R1 function", 32'(cfgFn), 32'h3);
    release_req();

    // vector table
    for (int v = 0; v < NV; v++) begin
      present(VECS[v].sz, VECS[v].wr, VECS[v].off, VECS[v].wd);
      chk(cfgEn == !VECS[v].fail, "R7 access strobe", 32'(cfgEn), 32'(!VECS[v].fail));
      chk(cfgWe == (VECS[v].wr && !VECS[v].fail), "R7 write strobe",
          32'(cfgWe), 32'(VECS[v].wr && !VECS[v].fail));
      @(posedge clk); #1;
      chk(rspDone == 1'b1, "R10 done", 32'(rspDone), 32'd1);
      chk(rspFail == VECS[v].fail, VECS[v].fail ? "R6 flag" : "R5 flag",
          32'(rspFail), 32'(VECS[v].fail));
      chk(rspStatus == (VECS[v].fail ? 8'h87 : 8'h00),
          VECS[v].fail ? "R6 status" : "R5 status",
          32'(rspStatus), VECS[v].fail ? 32'h87 : 32'h00);
      chk(rspRdata == VECS[v].rd, "R9 data", rspRdata, VECS[v].rd);
      release_req();
      @(posedge clk); #1;
      chk(rspDone == 1'b0, "R10 single pulse", 32'(rspDone), 32'd0);
    end

    // R8 lane enables and steering
    present(2'd1, 1'b0, 16'h000E, 32'h00001234);
    chk(cfgByteEn == 4'b1100, "R8 word enables", 32'(cfgByteEn), 32'hC);
    chk(cfgWdata[31:16] == 16'h1234, "R8 word lanes", cfgWdata, 32'h12340000);
    chk(cfgDwordAddr == 6'h03, "R8 word address", 32'(cfgDwordAddr), 32'h3);
    present(2'd0, 1'b0, 16'h0005, 32'h0000009A);
    chk(cfgByteEn == 4'b0010, "R8 byte enables", 32'(cfgByteEn), 32'h2);
    chk(cfgWdata[15:8] == 8'h9A, "R8 byte lane", cfgWdata, 32'h00009A00);
    present(2'd2, 1'b0, 16'h0008, 32'h0);
    chk(cfgByteEn == 4'b1111, "R8 dword enables", 32'(cfgByteEn), 32'hF);
    present(2'd1, 1'b0, 16'h0101, 32'h0);
    chk(cfgByteEn == 4'b0000, "R7 no enables on reject", 32'(cfgByteEn), 32'h0);
    release_req();
    @(posedge clk); #1;
    chk(rspFail == 1'b1, "R3 odd above range", 32'(rspFail), 32'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule